// File: doc/BRIEF.md
# Sparse Directory Cache

This block keeps coherence state only for blocks that some node currently caches. It does not hold one entry for every memory block. Entries sit in a set-associative array indexed by block address. Each valid entry stores a tag, a full presence vector with one bit per node, and a dirty flag. A request names a block address, a requesting node and an operation. The block finds the entry, returns its state as it was before the request, and applies the update.

A read or write that misses allocates an entry for the requesting node. There is no backing store behind the array, so an entry cannot simply be dropped when its set is full. The block picks a victim and sends an invalidation for every node recorded in that victim. The block address and the presence mask go out on a valid/ready port. The request that forced the eviction waits until that message is accepted, and only then is the new entry installed. The protocol engine that sends the messages, and memory, sit outside this block.

Top module: `sparse_dir_cache`

## Requirements
- R1: After reset every entry is invalid, so a probe of any address misses. After reset `respValid` and `invValid` are low and `reqReady` is high.
- R2: A request accepted while `reqReady` is high and needing no eviction raises `respValid` for exactly the next cycle. `respHit` is 1 on a hit, and `respSharers`/`respDirty` carry the entry's state before the update. On any miss all three are 0.
- R3: Operation encoding: `reqOp` 0 = read, 1 = write, 2 = drop, 3 = probe. A node's presence bit is bit `reqNode` of the vector. A read hit sets the requester's bit and clears dirty.
- R4: A write hit leaves only the requester's bit set and sets dirty.
- R5: A read or write miss installs an entry holding only the requester's bit. Dirty is 1 for a write and 0 for a read. The set index is `reqAddr[3:0]` and the tag is `reqAddr[11:4]`.
- R6: A drop hit clears the requester's bit and clears dirty. If no bit remains, the entry becomes invalid and its way can be reused without an eviction.
- R7: A probe never changes state. A drop or probe that misses allocates nothing.
- R8: A read or write miss to a set with all four ways valid raises `invValid` on the next cycle and drops `reqReady`. The new entry is installed on the cycle `invValid` and `invReady` are both high. The miss response follows one cycle later, and `reqReady` rises again at the same time.
- R9: Allocation takes the lowest-numbered invalid way first. In a full set the victim is the way with the fewest presence bits, with ties going to the lowest way. `invAddr` is the victim's full block address and `invMask` is its presence vector.
- R10: While `invValid` is high and `invReady` is low, `invAddr` and `invMask` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Request accepted on this cycle if valid |
| reqOp | input | 2 | Operation: 0 read, 1 write, 2 drop, 3 probe |
| reqAddr | input | 12 | Block address (tag in upper 8 bits, set in lower 4) |
| reqNode | input | 3 | Requesting node number |
| respValid | output | 1 | Response strobe |
| respHit | output | 1 | Request hit an existing entry |
| respSharers | output | 8 | Presence vector before the update |
| respDirty | output | 1 | Dirty flag before the update |
| invValid | output | 1 | Eviction invalidation pending |
| invReady | input | 1 | Invalidation message taken |
| invAddr | output | 12 | Block address of the evicted entry |
| invMask | output | 8 | Nodes that must drop the evicted block |

## Verification
A wrong entry in the array stays hidden until that block is touched again. The next access then returns the stale vector or dirty flag one cycle after it is accepted. It may also turn a hit into a miss, or the reverse. A wrong victim choice or a lost way shows up at the invalidation port one cycle after the miss. It appears as an eviction that should not happen, a wrong address or mask, or a missing eviction. The bench tracks the full array behaviourally and compares every output on every cycle, so any divergence is reported on the first cycle it reaches a port.

// File: rtl/sdc_pkg.sv
package sdc_pkg;

  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_WRITE = 2'd1,
    OP_DROP  = 2'd2,
    OP_PROBE = 2'd3
  } dirOp_e;

  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_EVICT = 1'b1
  } ctrlState_e;

  // Strobes from control to datapath; at most one is high per cycle.
  typedef struct packed {
    logic doAccess;      // handle the live request now
    logic captureEvict;  // latch the live request and its victim
    logic finishEvict;   // install the latched request into the victim way
  } ctrlStrobe_t;

endpackage

// File: rtl/sdc_control.sv
module sdc_control
  import sdc_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        invReady,
  input  logic        needEvict,
  output logic        reqReady,
  output logic        invValid,
  output ctrlStrobe_t strobe
);

  ctrlState_e stateQ, stateD;

  always_comb begin
    strobe   = '0;
    stateD   = stateQ;
    reqReady = (stateQ == ST_IDLE);
    invValid = (stateQ == ST_EVICT);
    unique case (stateQ)
      ST_IDLE: begin
        if (reqValid) begin
          if (needEvict) begin
            strobe.captureEvict = 1'b1;
            stateD = ST_EVICT;
          end else begin
            strobe.doAccess = 1'b1;
          end
        end
      end
      ST_EVICT: begin
        if (invReady) begin
          strobe.finishEvict = 1'b1;
          stateD = ST_IDLE;
        end
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

endmodule

// File: rtl/sdc_datapath.sv
module sdc_datapath
  import sdc_pkg::*;
#(
  parameter int SETS   = 16,
  parameter int WAYS   = 4,
  parameter int NODES  = 8,
  parameter int ADDR_W = 12,
  localparam int SET_W  = $clog2(SETS),
  localparam int TAG_W  = ADDR_W - SET_W,
  localparam int WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1,
  localparam int NODE_W = (NODES > 1) ? $clog2(NODES) : 1,
  localparam int CNT_W  = $clog2(NODES + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  dirOp_e            reqOp,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [NODE_W-1:0] reqNode,
  output logic              needEvict,
  output logic [ADDR_W-1:0] invAddr,
  output logic [NODES-1:0]  invMask,
  output logic              respValid,
  output logic              respHit,
  output logic [NODES-1:0]  respSharers,
  output logic              respDirty
);

  // Entry storage
  logic             validQ [SETS][WAYS];
  logic [TAG_W-1:0] tagQ   [SETS][WAYS];
  logic [NODES-1:0] shQ    [SETS][WAYS];
  logic             dirtyQ [SETS][WAYS];

  logic [SET_W-1:0] reqSet;
  logic [TAG_W-1:0] reqTag;
  logic [NODES-1:0] nodeBit;

  assign reqSet  = reqAddr[SET_W-1:0];
  assign reqTag  = reqAddr[ADDR_W-1:SET_W];
  assign nodeBit = NODES'(1) << reqNode;

  // Per-way view of the addressed set
  logic [WAYS-1:0]             wayValid, wayHit, wayDirty;
  logic [WAYS-1:0][NODES-1:0]  waySh;
  logic [WAYS-1:0][CNT_W-1:0]  wayCnt;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign wayValid[w] = validQ[reqSet][w];
    assign wayHit[w]   = validQ[reqSet][w] && (tagQ[reqSet][w] == reqTag);
    assign waySh[w]    = shQ[reqSet][w];
    assign wayDirty[w] = dirtyQ[reqSet][w];
    assign wayCnt[w]   = CNT_W'($countones(shQ[reqSet][w]));
  end

  // Hit, free way and victim selection
  logic             hitAny, freeAny, allocOp;
  logic [WAY_W-1:0] hitWay, freeWay, victimWay;

  always_comb begin
    hitAny    = 1'b0;
    hitWay    = '0;
    freeAny   = 1'b0;
    freeWay   = '0;
    victimWay = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (wayHit[w] && !hitAny) begin
        hitAny = 1'b1;
        hitWay = WAY_W'(w);
      end
      if (!wayValid[w] && !freeAny) begin
        freeAny = 1'b1;
        freeWay = WAY_W'(w);
      end
    end
    for (int w = 1; w < WAYS; w++) begin
      if (wayCnt[w] < wayCnt[victimWay]) victimWay = WAY_W'(w);
    end
  end

  assign allocOp   = (reqOp == OP_READ) || (reqOp == OP_WRITE);
  assign needEvict = allocOp && !hitAny && !freeAny;

  // Request latched across an eviction
  logic [SET_W-1:0]  pendSet;
  logic [TAG_W-1:0]  pendTag;
  logic [WAY_W-1:0]  pendWay;
  logic [NODES-1:0]  pendBit;
  logic              pendDirty;
  logic [ADDR_W-1:0] invAddrQ;
  logic [NODES-1:0]  invMaskQ;

  // Write port
  logic             wrEn, wrValid, wrDirty;
  logic [SET_W-1:0] wrSet;
  logic [WAY_W-1:0] wrWay;
  logic [TAG_W-1:0] wrTag;
  logic [NODES-1:0] wrSh;

  always_comb begin
    wrEn    = 1'b0;
    wrSet   = reqSet;
    wrWay   = hitWay;
    wrTag   = reqTag;
    wrSh    = nodeBit;
    wrDirty = 1'b0;
    if (strobe.doAccess) begin
      if (hitAny) begin
        unique case (reqOp)
          OP_READ: begin
            wrEn = 1'b1;
            wrSh = waySh[hitWay] | nodeBit;
          end
          OP_WRITE: begin
            wrEn    = 1'b1;
            wrDirty = 1'b1;
          end
          OP_DROP: begin
            wrEn = 1'b1;
            wrSh = waySh[hitWay] & ~nodeBit;
          end
          default: wrEn = 1'b0;
        endcase
      end else if (allocOp) begin
        wrEn    = 1'b1;
        wrWay   = freeWay;
        wrDirty = (reqOp == OP_WRITE);
      end
    end else if (strobe.finishEvict) begin
      wrEn    = 1'b1;
      wrSet   = pendSet;
      wrWay   = pendWay;
      wrTag   = pendTag;
      wrSh    = pendBit;
      wrDirty = pendDirty;
    end
    wrValid = |wrSh;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++)
          validQ[s][w] <= 1'b0;
      respValid   <= 1'b0;
      respHit     <= 1'b0;
      respSharers <= '0;
      respDirty   <= 1'b0;
      pendSet     <= '0;
      pendTag     <= '0;
      pendWay     <= '0;
      pendBit     <= '0;
      pendDirty   <= 1'b0;
      invAddrQ    <= '0;
      invMaskQ    <= '0;
    end else begin
      if (wrEn) validQ[wrSet][wrWay] <= wrValid;
      respValid <= strobe.doAccess || strobe.finishEvict;
      if (strobe.doAccess) begin
        respHit     <= hitAny;
        respSharers <= hitAny ? waySh[hitWay] : '0;
        respDirty   <= hitAny && wayDirty[hitWay];
      end else if (strobe.finishEvict) begin
        respHit     <= 1'b0;
        respSharers <= '0;
        respDirty   <= 1'b0;
      end
      if (strobe.captureEvict) begin
        pendSet   <= reqSet;
        pendTag   <= reqTag;
        pendWay   <= victimWay;
        pendBit   <= nodeBit;
        pendDirty <= (reqOp == OP_WRITE);
        invAddrQ  <= {tagQ[reqSet][victimWay], reqSet};
        invMaskQ  <= waySh[victimWay];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wrEn) begin
      tagQ[wrSet][wrWay]   <= wrTag;
      shQ[wrSet][wrWay]    <= wrSh;
      dirtyQ[wrSet][wrWay] <= wrDirty;
    end
  end

  assign invAddr = invAddrQ;
  assign invMask = invMaskQ;

endmodule

// File: rtl/sparse_dir_cache.sv
module sparse_dir_cache
  import sdc_pkg::*;
#(
  parameter int SETS   = 16,
  parameter int WAYS   = 4,
  parameter int NODES  = 8,
  parameter int ADDR_W = 12,
  localparam int NODE_W = (NODES > 1) ? $clog2(NODES) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [1:0]        reqOp,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [NODE_W-1:0] reqNode,
  output logic              respValid,
  output logic              respHit,
  output logic [NODES-1:0]  respSharers,
  output logic              respDirty,
  output logic              invValid,
  input  logic              invReady,
  output logic [ADDR_W-1:0] invAddr,
  output logic [NODES-1:0]  invMask
);

  ctrlStrobe_t strobe;
  logic        needEvict;
  dirOp_e      opE;

  assign opE = dirOp_e'(reqOp);

  sdc_control u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .invReady  (invReady),
    .needEvict (needEvict),
    .reqReady  (reqReady),
    .invValid  (invValid),
    .strobe    (strobe)
  );

  sdc_datapath #(
    .SETS   (SETS),
    .WAYS   (WAYS),
    .NODES  (NODES),
    .ADDR_W (ADDR_W)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .reqOp       (opE),
    .reqAddr     (reqAddr),
    .reqNode     (reqNode),
    .needEvict   (needEvict),
    .invAddr     (invAddr),
    .invMask     (invMask),
    .respValid   (respValid),
    .respHit     (respHit),
    .respSharers (respSharers),
    .respDirty   (respDirty)
  );

endmodule

// File: rtl/sparse_dir_cache_chk.sv
module sparse_dir_cache_chk #(
  parameter int ADDR_W = 12,
  parameter int NODES  = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqReady,
  input logic              respValid,
  input logic              respHit,
  input logic [NODES-1:0]  respSharers,
  input logic              respDirty,
  input logic              invValid,
  input logic              invReady,
  input logic [ADDR_W-1:0] invAddr,
  input logic [NODES-1:0]  invMask
);

  // R2: an accepted request yields either a response or an eviction next cycle
  p_accept_outcome_r2: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqReady |=> (respValid ^ invValid));

  // R2: no response without a handshake on the previous cycle
  p_no_spurious_resp_r2: assert property (@(posedge clk) disable iff (!rstN)
    respValid |-> ($past(reqValid && reqReady) || $past(invValid && invReady)));

  // R2: a hit always reports at least one sharer
  p_hit_has_sharer_r2: assert property (@(posedge clk) disable iff (!rstN)
    respValid && respHit |-> (respSharers != '0));

  // R5: a miss reports an empty state
  p_miss_empty_r5: assert property (@(posedge clk) disable iff (!rstN)
    respValid && !respHit |-> (respSharers == '0) && !respDirty);

  // R8: requests are stalled while an invalidation is pending
  p_stall_r8: assert property (@(posedge clk) disable iff (!rstN)
    invValid |-> !reqReady);

  // R8: the stalled miss completes one cycle after the handshake
  p_evict_resp_r8: assert property (@(posedge clk) disable iff (!rstN)
    invValid && invReady |=> respValid && !respHit && reqReady && !invValid);

  // R9: a victim always has sharers to invalidate
  p_victim_mask_r9: assert property (@(posedge clk) disable iff (!rstN)
    invValid |-> (invMask != '0));

  // R10: the message is held until taken
  p_inv_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    invValid && !invReady |=> invValid && $stable(invAddr) && $stable(invMask));

endmodule

bind sparse_dir_cache sparse_dir_cache_chk #(.ADDR_W(ADDR_W), .NODES(NODES)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .reqValid    (reqValid),
  .reqReady    (reqReady),
  .respValid   (respValid),
  .respHit     (respHit),
  .respSharers (respSharers),
  .respDirty   (respDirty),
  .invValid    (invValid),
  .invReady    (invReady),
  .invAddr     (invAddr),
  .invMask     (invMask)
);

// File: tb/sparse_dir_cache_test.sv
`timescale 1ns/1ps
module sparse_dir_cache_test;

  localparam int NS = 16;
  localparam int NW = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [1:0]  reqOp = 2'd0;
  logic [11:0] reqAddr = '0;
  logic [2:0]  reqNode = '0;
  logic        respValid, respHit, respDirty;
  logic [7:0]  respSharers;
  logic        invValid;
  logic [11:0] invAddr;
  logic [7:0]  invMask;
  logic        invHold = 1'b1;
  logic        invRand = 1'b1;
  logic        rndInv = 1'b0;
  logic        invReady;

  assign invReady = rndInv ? invRand : invHold;

  always #4 clk = ~clk;  // 125 MHz

  sparse_dir_cache uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqOp(reqOp), .reqAddr(reqAddr), .reqNode(reqNode),
    .respValid(respValid), .respHit(respHit), .respSharers(respSharers),
    .respDirty(respDirty), .invValid(invValid), .invReady(invReady),
    .invAddr(invAddr), .invMask(invMask)
  );

  int    nChecks = 0;
  int    nErrors = 0;
  string curTag = "R1";
  bit    finished = 1'b0;
  int    cycles = 0;

  // Behavioural reference: way slots per set
  bit       mV  [NS][NW];
  int       mTag[NS][NW];
  bit [7:0] mSh [NS][NW];
  bit       mD  [NS][NW];
  int       mState = 0;
  int       pSet, pTag, pWay;
  bit [7:0] pBit;
  bit       pDirty;
  bit       eRespValid = 0, eHit = 0, eDirty = 0, eInvValid = 0;
  bit [7:0] eSh = 0, eInvMask = 0;
  int       eInvAddr = 0;

  always @(posedge clk) begin : model
    int s, t, hw, fw, vw;
    bit [7:0] b;
    if (!rstN) begin
      for (int i = 0; i < NS; i++) for (int j = 0; j < NW; j++) mV[i][j] = 0;
      mState = 0; eRespValid = 0; eInvValid = 0;
    end else begin
      eRespValid = 0;
      if (mState == 0 && reqValid) begin
        s = reqAddr % 16; t = reqAddr / 16; b = 8'(1 << reqNode);
        hw = -1; fw = -1;
        for (int w = NW - 1; w >= 0; w--) begin
          if (mV[s][w] && mTag[s][w] == t) hw = w;
          if (!mV[s][w]) fw = w;
        end
        if (hw >= 0) begin
          eRespValid = 1; eHit = 1; eSh = mSh[s][hw]; eDirty = mD[s][hw];
          case (reqOp)
            2'd0: begin mSh[s][hw] = mSh[s][hw] | b; mD[s][hw] = 0; end
            2'd1: begin mSh[s][hw] = b; mD[s][hw] = 1; end
            2'd2: begin
              mSh[s][hw] = mSh[s][hw] & ~b; mD[s][hw] = 0;
              if (mSh[s][hw] == 0) mV[s][hw] = 0;
            end
            default: ;
          endcase
        end else if (reqOp <= 2'd1 && fw >= 0) begin
          mV[s][fw] = 1; mTag[s][fw] = t; mSh[s][fw] = b; mD[s][fw] = (reqOp == 2'd1);
          eRespValid = 1; eHit = 0; eSh = 0; eDirty = 0;
        end else if (reqOp <= 2'd1) begin
          vw = 0;
          for (int w = 1; w < NW; w++)
            if ($countones(mSh[s][w]) < $countones(mSh[s][vw])) vw = w;
          pSet = s; pTag = t; pWay = vw; pBit = b; pDirty = (reqOp == 2'd1);
          eInvValid = 1; eInvAddr = mTag[s][vw] * 16 + s; eInvMask = mSh[s][vw];
          mState = 1;
        end else begin
          eRespValid = 1; eHit = 0; eSh = 0; eDirty = 0;
        end
      end else if (mState == 1 && invReady) begin
        mV[pSet][pWay] = 1; mTag[pSet][pWay] = pTag; mSh[pSet][pWay] = pBit;
        mD[pSet][pWay] = pDirty;
        eRespValid = 1; eHit = 0; eSh = 0; eDirty = 0;
        eInvValid = 0; mState = 0;
      end
    end
  end

  task automatic check(string what, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nErrors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", curTag, what, act, exp);
    end
  endtask

  // Compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (rstN && !finished) begin
      check("reqReady", int'(reqReady), (mState == 0) ? 1 : 0);
      check("respValid", int'(respValid), int'(eRespValid));
      if (eRespValid) begin
        check("respHit", int'(respHit), int'(eHit));
        check("respSharers", int'(respSharers), int'(eSh));
        check("respDirty", int'(respDirty), int'(eDirty));
      end
      check("invValid", int'(invValid), int'(eInvValid));
      if (eInvValid) begin
        check("invAddr", int'(invAddr), eInvAddr);
        check("invMask", int'(invMask), int'(eInvMask));
      end
    end
    if (rndInv) invRand <= ($urandom % 3) != 0;
  end

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !finished) begin
      nChecks++; nErrors++;
      $display("FAIL watchdog: actual=%0d expected<=100000 cycles", cycles);
      summary();
    end
  end

  task automatic issue(int op, int addr, int node);
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    reqValid = 1'b1; reqOp = 2'(op); reqAddr = 12'(addr); reqNode = 3'(node);
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: empty after reset
    curTag = "R1";
    @(negedge clk);
    issue(3, 12'h005, 0);
    issue(3, 12'h3A2, 7);
    // R5: allocation on read and write misses
    curTag = "R5";
    issue(0, 12'h010, 2);
    issue(1, 12'h021, 5);
    issue(3, 12'h021, 0);
    // R2 / R3: read hits add sharers, return prior state
    curTag = "R3";
    issue(0, 12'h010, 4);
    issue(3, 12'h010, 0);
    // R4: write hit leaves only the writer
    curTag = "R4";
    issue(1, 12'h010, 7);
    issue(0, 12'h010, 1);
    issue(3, 12'h010, 0);
    // R7: drop/probe misses allocate nothing
    curTag = "R7";
    issue(2, 12'h0F0, 0);
    issue(3, 12'h0F0, 0);
    issue(3, 12'h0F0, 0);
    // R9: fill set 3 with 3,2,2,3 sharers
    curTag = "R9";
    issue(0, 12'h013, 0); issue(0, 12'h013, 1); issue(0, 12'h013, 2);
    issue(0, 12'h023, 0); issue(0, 12'h023, 1);
    issue(0, 12'h033, 3); issue(0, 12'h033, 4);
    issue(0, 12'h043, 5); issue(0, 12'h043, 6); issue(0, 12'h043, 7);
    // R8 / R10: eviction of way 1 held three cycles
    curTag = "R10";
    invHold = 1'b0;
    issue(0, 12'h053, 0);
    repeat (3) @(negedge clk);
    curTag = "R8";
    invHold = 1'b1;
    issue(1, 12'h063, 2);   // victim is now the single-sharer way
    issue(3, 12'h063, 0);
    issue(3, 12'h023, 0);
    // R6: emptying an entry frees its way
    curTag = "R6";
    issue(2, 12'h033, 3);
    issue(2, 12'h033, 4);
    issue(3, 12'h033, 0);
    issue(0, 12'h073, 1);
    issue(3, 12'h073, 0);
    // R2: mixed traffic on two sets with back-pressure on invalidations
    curTag = "R2";
    rndInv = 1'b1;
    for (int i = 0; i < 500; i++)
      issue($urandom % 4, (1 + $urandom % 6) * 16 + 5 + ($urandom % 2), $urandom % 8);
    rndInv = 1'b0;
    repeat (6) @(negedge clk);
    summary();
  end

endmodule